// File: doc/BRIEF.md
# External Memory Bus Bridge

This block connects a processor's table read and table write requests to an external parallel memory bus. A request carries an address, a direction and one data byte. The block then drives the bus address, the output enable or the write strobes, and the 16-bit data bus. When the access is complete, it returns a one-cycle completion pulse to the requester. A read returns the selected byte of the bus data.

An 8-bit configuration register sets three things:
- whether the bus keeps the pins permanently or takes them only during an access;
- how many wait cycles each access gets;
- how a byte write is presented on a 16-bit bus.

There are three 16-bit write schemes:
- **Word mode** parks the even byte in a holding latch and writes both bytes on the odd write.
- **Byte-select mode** uses one write strobe plus an upper or lower byte select.
- **Byte-write mode** uses separate high and low write strobes.

An input tells the block whether the register may be written at all. A second input selects an 8-bit or 16-bit data path.

Top module: `ext_bus_bridge`

## Requirements
- R1: After reset the register reads 0x00, `pinOwnBus` is 1, no strobe or output enable is asserted, and the holding latch holds 0x00.
- R2: Register write data bit 7 is the bus-disable bit, bits 5:4 are the wait field and bits 1:0 are the write mode. Read-back bits 6, 3 and 2 are always 0, so writing 0xFF reads back 0xB3.
- R3: While `regEnable` is 0, register writes are ignored and the read-back value does not change.
- R4: With bus-disable at 0, `pinOwnBus` is 1 at all times. With bus-disable at 1, `pinOwnBus` is 1 only during the cycles in which an access drives the bus, and 0 otherwise.
- R5: An access asserts its strobe for 1+N cycles, where the wait field maps 11→N=0, 10→1, 01→2 and 00→3. `reqDone` is high for exactly one cycle, immediately after the last strobe cycle.
- R6: In 16-bit width with write mode 1x, a write to an even address (address bit 0 = 0) stores the byte in the holding latch. It asserts no strobe and no output enable, and `reqDone` follows one cycle after the request is accepted.
- R7: In 16-bit width with write mode 1x, a write to an odd address drives `busDataOut = {new byte, latched byte}` and asserts `wrHigh` only.
- R8: In 16-bit width with write mode 01, the byte appears on both halves of `busDataOut`. `wrHigh` is asserted with `selUpper` for an odd address, or with `selLower` for an even address.
- R9: In 16-bit width with write mode 00, the byte appears on both halves of `busDataOut`. `wrHigh` alone is asserted for an odd address, and `wrLow` alone for an even address.
- R10: In 8-bit width the write mode has no effect: a write drives `{8'h00, byte}`, asserts `wrLow` only and never uses the holding latch.
- R11: A read drives `busAddr` and `memOe` for the strobe window, with no write strobe and `busDataOe` low. At `reqDone`, `rdData` holds `busDataIn[15:8]` for an odd address in 16-bit width, and `busDataIn[7:0]` otherwise.
- R12: During a write strobe, `busDataOe` is 1 and `busDataOut` and `busAddr` stay stable.
- R13: Each new even-address word-mode write overwrites the holding latch. A later odd write uses the most recent even byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regEnable | input | 1 | 1 when the current memory mode permits register writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read-back value |
| busWide | input | 1 | 1 selects the 16-bit data path, 0 the 8-bit path |
| reqValid | input | 1 | Access request, sampled while idle |
| reqWrite | input | 1 | 1 for a table write, 0 for a table read |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWrData | input | 8 | Write data byte |
| reqDone | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Read result, valid from `reqDone` onward |
| busAddr | output | ADDR_W | External address, zero when idle |
| busDataOut | output | 16 | External write data |
| busDataOe | output | 1 | Data output enable during write strobes |
| busDataIn | input | 16 | External read data |
| memOe | output | 1 | Memory output enable, asserted for reads |
| wrHigh | output | 1 | High write strobe |
| wrLow | output | 1 | Low write strobe |
| selUpper | output | 1 | Upper-byte select |
| selLower | output | 1 | Lower-byte select |
| pinOwnBus | output | 1 | 1 when the bus owns the shared pins, 0 for general I/O |

## Verification
The bench sweeps every wait code against each write mode, both data widths, both directions and both address parities. It computes the strobe length, the strobe set and the data pattern from the requirements.

The inverted wait encoding is a key target. A design that used the field directly would produce strobes of length 4 where 1 is expected.

The holding latch gets two targets:
- An odd write straight after reset must carry 0x00 in the low half.
- Two back-to-back even writes must leave only the second byte; stale or first-written bytes expose a latch that is loaded wrongly.

Other mistakes the sweep reports:
- A parity swap shows up as `wrLow` where `wrHigh` belongs.
- A design that let the 8-bit path honour the write mode would show a strobe on the wrong lane.
- A design that dropped the locked register write would show up in the read-back value.
- A design that left the pins with the bus when idle would show up in `pinOwnBus`.

// File: rtl/embus_pkg.sv
package embus_pkg;

  typedef struct packed {
    logic capture;    // load request fields into the datapath
    logic latchLoad;  // store write byte into the holding latch
    logic rdCapture;  // sample read data on the last strobe cycle
    logic active;     // strobe window in progress
  } busCmd_t;

  localparam int WAIT_W = 2;
  localparam int MODE_W = 2;

  // wait field is inverted: all-ones means no wait
  function automatic logic [WAIT_W-1:0] waitsFromField(input logic [WAIT_W-1:0] f);
    return ~f;
  endfunction

endpackage

// File: rtl/embus_cfg_reg.sv
module embus_cfg_reg
  import embus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEnable,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              busDisable,
  output logic [WAIT_W-1:0] waitField,
  output logic [MODE_W-1:0] wrMode
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busDisable <= 1'b0;
      waitField  <= '0;
      wrMode     <= '0;
    end else if (regWrEn && regEnable) begin
      busDisable <= regWrData[7];
      waitField  <= regWrData[5:4];
      wrMode     <= regWrData[1:0];
    end
  end

  assign regRdData = {busDisable, 1'b0, waitField, 2'b00, wrMode};

  // R3: a locked register keeps its value
  assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regEnable) |=> $stable(regRdData));

endmodule

// File: rtl/embus_ctrl.sv
module embus_ctrl
  import embus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqAddrLsb,
  input  logic              busWide,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [WAIT_W-1:0] waitField,
  output busCmd_t           cmd,
  output logic              reqDone
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_DONE} state_t;

  localparam int LEN_W = WAIT_W + 1;

  state_t            state;
  logic [WAIT_W-1:0] waitCnt;
  logic              latchOnly;
  logic              accept;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign latchOnly = reqWrite && busWide && wrMode[1] && !reqAddrLsb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state   <= latchOnly ? ST_DONE : ST_ACCESS;
          waitCnt <= waitsFromField(waitField);
        end
        ST_ACCESS: begin
          if (waitCnt == '0) state <= ST_DONE;
          else               waitCnt <= waitCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.capture   = accept;
    cmd.latchLoad = accept && latchOnly;
    cmd.active    = (state == ST_ACCESS);
    cmd.rdCapture = (state == ST_ACCESS) && (waitCnt == '0);
  end

  assign reqDone = (state == ST_DONE);

  // checker state: measured and expected strobe length
  logic [LEN_W-1:0] lenCnt;
  logic [LEN_W-1:0] lenExp;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCnt <= '0;
      lenExp <= '0;
    end else if (accept) begin
      lenCnt <= '0;
      lenExp <= LEN_W'(waitsFromField(waitField)) + 1'b1;
    end else if (state == ST_ACCESS) begin
      lenCnt <= lenCnt + 1'b1;
    end
  end

  assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdCapture |-> (lenCnt + 1'b1 == lenExp));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

endmodule

// File: rtl/embus_datapath.sv
module embus_datapath
  import embus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWrData,
  input  logic              busWide,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [15:0]       busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busDataOut,
  output logic              busDataOe,
  output logic              memOe,
  output logic              wrHigh,
  output logic              wrLow,
  output logic              selUpper,
  output logic              selLower,
  output logic [7:0]        rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              writeQ;
  logic              wideQ;
  logic [MODE_W-1:0] modeQ;
  logic [7:0]        holdLatch;
  logic              oddQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      dataQ     <= '0;
      writeQ    <= 1'b0;
      wideQ     <= 1'b0;
      modeQ     <= '0;
      holdLatch <= '0;
      rdData    <= '0;
    end else begin
      if (cmd.capture) begin
        addrQ  <= reqAddr;
        dataQ  <= reqWrData;
        writeQ <= reqWrite;
        wideQ  <= busWide;
        modeQ  <= wrMode;
      end
      if (cmd.latchLoad) holdLatch <= reqWrData;
      if (cmd.rdCapture && !writeQ)
        rdData <= (wideQ && addrQ[0]) ? busDataIn[15:8] : busDataIn[7:0];
    end
  end

  assign oddQ = addrQ[0];

  always_comb begin
    busAddr    = '0;
    busDataOut = '0;
    busDataOe  = 1'b0;
    memOe      = 1'b0;
    wrHigh     = 1'b0;
    wrLow      = 1'b0;
    selUpper   = 1'b0;
    selLower   = 1'b0;
    if (cmd.active) begin
      busAddr = addrQ;
      if (!writeQ) begin
        memOe = 1'b1;
      end else begin
        busDataOe = 1'b1;
        if (!wideQ) begin
          busDataOut = {8'h00, dataQ};
          wrLow      = 1'b1;
        end else if (modeQ[1]) begin
          busDataOut = {dataQ, holdLatch};
          wrHigh     = 1'b1;
        end else if (modeQ[0]) begin
          busDataOut = {dataQ, dataQ};
          wrHigh     = 1'b1;
          selUpper   = oddQ;
          selLower   = !oddQ;
        end else begin
          busDataOut = {dataQ, dataQ};
          wrHigh     = oddQ;
          wrLow      = !oddQ;
        end
      end
    end
  end

  // R12: data and address hold steady across a multi-cycle write strobe
  assert_wdata_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((wrHigh || wrLow) && $past(wrHigh || wrLow)) |-> ($stable(busDataOut) && $stable(busAddr)));

  // R8: byte selects never both active
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selUpper, selLower}));

  // R11: output enable and write strobes are exclusive
  assert_oe_vs_wr_R11: assert property (@(posedge clk) disable iff (!rstN)
    memOe |-> !(wrHigh || wrLow || busDataOe));

endmodule

// File: rtl/ext_bus_bridge.sv
module ext_bus_bridge
  import embus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEnable,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              busWide,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWrData,
  output logic              reqDone,
  output logic [7:0]        rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busDataOut,
  output logic              busDataOe,
  input  logic [15:0]       busDataIn,
  output logic              memOe,
  output logic              wrHigh,
  output logic              wrLow,
  output logic              selUpper,
  output logic              selLower,
  output logic              pinOwnBus
);

  busCmd_t           cmd;
  logic              busDisable;
  logic [WAIT_W-1:0] waitField;
  logic [MODE_W-1:0] wrMode;

  embus_cfg_reg cfgReg (
    .clk, .rstN, .regEnable, .regWrEn, .regWrData, .regRdData,
    .busDisable, .waitField, .wrMode
  );

  embus_ctrl ctrl (
    .clk, .rstN, .reqValid, .reqWrite, .reqAddrLsb(reqAddr[0]),
    .busWide, .wrMode, .waitField, .cmd, .reqDone
  );

  embus_datapath #(.ADDR_W(ADDR_W)) dpath (
    .clk, .rstN, .cmd, .reqWrite, .reqAddr, .reqWrData, .busWide, .wrMode,
    .busDataIn, .busAddr, .busDataOut, .busDataOe, .memOe, .wrHigh, .wrLow,
    .selUpper, .selLower, .rdData
  );

  assign pinOwnBus = !busDisable || cmd.active;

  // R4: a strobe may only appear while the bus owns the pins
  assert_pins_owned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memOe || wrHigh || wrLow) |-> pinOwnBus);

endmodule

// File: tb/ext_bus_bridge_test.sv
module ext_bus_bridge_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regEnable = 1'b1, regWrEn = 1'b0;
  logic [7:0]    regWrData = '0, regRdData;
  logic          busWide = 1'b1, reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqWrData = '0, rdData;
  logic          reqDone;
  logic [AW-1:0] busAddr;
  logic [15:0]   busDataOut, busDataIn = '0;
  logic          busDataOe, memOe, wrHigh, wrLow, selUpper, selLower, pinOwnBus;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] latchModel = 8'h00;

  always #2 clk = ~clk;

  ext_bus_bridge #(.ADDR_W(AW)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  // one access; all expectations derived from the requirements
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic wide, input logic [1:0] mode, input logic [1:0] wf,
                        input logic dis);
    int strobeLen = 0;
    int expLen;
    logic [15:0] firstOut = '0;
    logic [3:0]  firstStb = '0;
    logic [AW-1:0] firstAddr = '0;
    logic        firstOe = 1'b0, firstDOe = 1'b0;
    logic        unstable = 1'b0, ownBad = 1'b0;
    logic [15:0] din;
    logic        latchOnly;
    logic [15:0] expOut;
    logic [3:0]  expStb; // {wrHigh,wrLow,selUpper,selLower}
    logic        done = 1'b0;
    din = {8'hC0 ^ d, 8'h3C ^ d};
    latchOnly = wr && wide && mode[1] && !a[0];
    expLen = latchOnly ? 0 : 1 + (3 - int'(wf));
    expOut = '0; expStb = '0;
    if (wr && !latchOnly) begin
      if (!wide)        begin expOut = {8'h00, d};   expStb = 4'b0100; end
      else if (mode[1]) begin expOut = {d, latchModel}; expStb = 4'b1000; end
      else if (mode[0]) begin expOut = {d, d}; expStb = a[0] ? 4'b1010 : 4'b1001; end
      else              begin expOut = {d, d}; expStb = a[0] ? 4'b1000 : 4'b0100; end
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWrData = d; busWide = wide; busDataIn = din;
    for (int t = 0; t < 12 && !done; t++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (reqDone) done = 1'b1;
      else if (memOe || wrHigh || wrLow) begin
        if (strobeLen == 0) begin
          firstOut = busDataOut; firstStb = {wrHigh, wrLow, selUpper, selLower};
          firstAddr = busAddr; firstOe = memOe; firstDOe = busDataOe;
        end else if (busDataOut !== firstOut || busAddr !== firstAddr) unstable = 1'b1;
        if (!pinOwnBus) ownBad = 1'b1;
        strobeLen++;
      end
    end
    check("R5 done seen", done, 1);
    check("R5 strobe length (R6 when latch-only)", strobeLen, expLen);
    if (strobeLen > 0) begin
      check("R4 pins owned during access", ownBad, 0);
      check("R11 address driven", firstAddr, a);
      if (wr) begin
        check("R7/R8/R9/R10 write data", firstOut, expOut);
        check("R7/R8/R9/R10 strobe set", firstStb, expStb);
        check("R12 data stable and driven", {unstable, firstDOe}, 2'b01);
      end else begin
        check("R11 read strobes", {firstOe, firstStb, firstDOe}, 6'b100000);
      end
    end
    if (!wr) check("R11 read data", rdData, (wide && a[0]) ? din[15:8] : din[7:0]);
    @(negedge clk);
    check("R4 pins after access", pinOwnBus, !dis);
    if (latchOnly) latchModel = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reg reset", regRdData, 8'h00);
    check("R1 pins reset", pinOwnBus, 1);
    check("R1 no strobes", {memOe, wrHigh, wrLow, selUpper, selLower, busDataOe}, 6'b0);
    // R2 layout
    writeReg(8'hFF);
    check("R2 readback", regRdData, 8'hB3);
    // R3 locked
    regEnable = 1'b0;
    writeReg(8'h00);
    check("R3 locked write ignored", regRdData, 8'hB3);
    regEnable = 1'b1;
    // R1/R13: latch is zero after reset, word mode, no wait, bus-disable set
    writeReg(8'hB3);
    access(1'b1, 16'h0021, 8'h5A, 1'b1, 2'b11, 2'b11, 1'b1);
    // R13: two even writes, odd write takes the second
    access(1'b1, 16'h0040, 8'h11, 1'b1, 2'b11, 2'b11, 1'b1);
    access(1'b1, 16'h0042, 8'h22, 1'b1, 2'b11, 2'b11, 1'b1);
    access(1'b1, 16'h0043, 8'h33, 1'b1, 2'b11, 2'b11, 1'b1);
    check("R13 latch holds last even byte", latchModel, 8'h22);
    // R4 with bus-disable cleared: bus keeps pins
    writeReg(8'h20);
    check("R4 bus owns pins idle", pinOwnBus, 1);
    access(1'b0, 16'h0105, 8'h00, 1'b1, 2'b00, 2'b10, 1'b0);
    // full sweep
    for (int wf = 0; wf < 4; wf++)
      for (int m = 0; m < 4; m++) begin
        writeReg({1'b1, 1'b0, 2'(wf), 2'b00, 2'(m)});
        for (int w = 0; w < 2; w++)
          for (int wr = 0; wr < 2; wr++)
            for (int p = 0; p < 2; p++)
              access(wr[0], AW'(16'h0200 + wf*64 + m*16 + w*8 + wr*4 + p),
                     8'(8'h17 * (wf*16 + m*8 + w*4 + wr*2 + p) + 1),
                     w[0], 2'(m), 2'(wf), 1'b1);
      end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule